// File: doc/BRIEF.md
# Snooping MESI Cache Controller

This block manages a small direct-mapped copy-back data cache for one core and keeps it coherent with other caches on a shared snooping bus. Each line holds one data word, a tag, and a two-bit MESI state. The core issues single-word reads and writes. The controller answers hits locally. It uses the bus for misses, for upgrades from Shared and for dirty evictions. It also watches the transactions of other masters and updates or supplies its own lines in response.

The bus exchange has two phases. The first is a one-cycle address phase, made once a grant is present. In that same cycle every snooper answers with a shared flag, a retry flag and, optionally, intervention data. The second is a data phase that ends when the memory side pulses `bus_done`, with fill data on `bus_rdata`. A peer that intervenes cancels the memory read. A snooper that holds a dirty copy and sees a read-for-ownership forces a retry. It then writes its copy back and drops it. The requester repeats the transaction, which then finds no other copy.

The main state machine has four states: `S_IDLE`, `S_ARB`, `S_WAIT` and `S_RESP`.
- **IDLE→RESP**: a local hit that needs no bus.
- **IDLE→ARB**: a miss, a Shared write, or a pending forced write-back.
- **ARB→WAIT**: a granted RD, RWITM or WB.
- **ARB→ARB**: a retried request.
- **ARB→RESP**: an INV upgrade.
- **ARB→IDLE**: the line changed while the request waited, so no bus work remains.
- **WAIT→ARB**: a victim write-back has finished.
- **WAIT→RESP**: a fill has finished.
- **WAIT→IDLE**: a forced write-back has finished.
- **RESP→IDLE**: always, after the one response cycle.

Top module: `coh_cache_ctl`

## Requirements
- R1: After reset every line is Invalid, `core_ready` and `bus_req` are low, and the first core read of any address issues a bus RD. Bus command codes: 0 none, 1 RD, 2 RWITM, 3 INV, 4 WB.
- R2: A read hit returns the stored word with `core_ready` high for exactly one cycle. It issues no bus command and leaves the line state unchanged.
- R3: A read miss with `bus_shared_in` low in the address phase fills the line from `bus_rdata` as Exclusive.
- R4: A read miss with `bus_shared_in` high fills the line as Shared, so a later write to it issues INV.
- R5: A snooped RD that hits a line in E or S raises `snp_shared` and `snp_ivn` with the line's word, with `snp_ivn_dirty` low. An Exclusive line becomes Shared.
- R6: A snooped RD that hits a Modified line raises `snp_shared`, `snp_ivn` and `snp_ivn_dirty` with the dirty word, and the line becomes Shared.
- R7: A write hit in E or M updates the word and leaves the line Modified without any bus command.
- R8: A write hit in S issues INV for that address, then updates the word and becomes Modified. A snooped INV that hits a Shared line makes it Invalid.
- R9: A write miss issues RWITM, fills the line, applies the core's word and becomes Modified.
- R10: A snooped RWITM that hits E or S raises `snp_shared` without `snp_retry`, and the line becomes Invalid.
- R11: A snooped RWITM that hits M raises `snp_retry`. The controller then requests the bus, writes the line back with WB carrying its address and word, and sets the line to Invalid.
- R12: A miss whose victim is Modified first issues WB of the victim's address and word, then the fill. A victim in E or S is dropped with no WB.
- R13: A snoop whose tag differs from the stored tag of the indexed line raises no snoop output and changes nothing.
- R14: A RD or RWITM that sees `bus_retry_in` in its address phase is issued again, and the access completes after the retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core access request, held until `core_ready` |
| core_we | input | 1 | 1 for a write, 0 for a read |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Write word |
| core_rdata | output | DATA_W | Read word, valid with `core_ready` |
| core_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 3 | Command in the address phase |
| bus_addr | output | ADDR_W | Address in the address phase |
| bus_wdata | output | DATA_W | Write-back word for WB |
| bus_rdata | input | DATA_W | Fill word, valid with `bus_done` |
| bus_done | input | 1 | Data phase complete |
| bus_shared_in | input | 1 | Wired-OR shared response from peers |
| bus_retry_in | input | 1 | Retry response from peers |
| snp_valid | input | 1 | Another master's address phase is on the bus |
| snp_cmd | input | 3 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy |
| snp_retry | output | 1 | This cache blocks the RWITM |
| snp_ivn | output | 1 | This cache supplies the data |
| snp_ivn_dirty | output | 1 | The supplied data is dirty and must reach memory |
| snp_ivn_data | output | DATA_W | Supplied word |

## Verification
The hardest situation to reach is a dirty snoop hit on a read-for-ownership. It needs a line that this cache made Modified through a write miss. A peer RWITM must then arrive at that same line while the controller is idle, and the test must then watch a write-back that the core never asked for. The stimulus first writes an address so that a local RWITM makes the line Modified, then presents the peer RWITM on the snoop inputs. It checks the retry in that same cycle, and then checks the WB command, address and word in the bus log. A later local read of that address must go to the bus, which shows that the line was dropped. The retry path on the requester side is reached in a similar way: the bus model refuses the controller's own RD once and counts that it is issued twice.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_RD    = 3'd1,
        CMD_RWITM = 3'd2,
        CMD_INV   = 3'd3,
        CMD_WB    = 3'd4
    } bcmd_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARB  = 2'd1,
        S_WAIT = 2'd2,
        S_RESP = 2'd3
    } fsm_t;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_RWITM = 2'd1,
        OP_WBV   = 2'd2,
        OP_WBS   = 2'd3
    } op_t;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output mesi_t             a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_dat,
    input  logic [IDX_W-1:0]  b_idx,
    output mesi_t             b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_dat,
    input  logic [IDX_W-1:0]  c_idx,
    output logic [TAG_W-1:0]  c_tag,
    output logic [DATA_W-1:0] c_dat,
    input  logic              f_we,
    input  logic              f_fill,
    input  logic [IDX_W-1:0]  f_idx,
    input  mesi_t             f_st,
    input  logic [TAG_W-1:0]  f_tag,
    input  logic [DATA_W-1:0] f_dat,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_idx,
    input  mesi_t             s_st
);

    mesi_t             st_q  [SETS];
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SETS; i++) begin
                if (s_we && s_idx == IDX_W'(i))
                    st_q[i] <= s_st;
                else if (f_we && f_idx == IDX_W'(i))
                    st_q[i] <= f_st;
                if (f_we && f_fill && f_idx == IDX_W'(i)) begin
                    tag_q[i] <= f_tag;
                    dat_q[i] <= f_dat;
                end
            end
        end
    end

    assign a_st  = st_q[a_idx];
    assign a_tag = tag_q[a_idx];
    assign a_dat = dat_q[a_idx];
    assign b_st  = st_q[b_idx];
    assign b_tag = tag_q[b_idx];
    assign b_dat = dat_q[b_idx];
    assign c_tag = tag_q[c_idx];
    assign c_dat = dat_q[c_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  mesi_t             line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_dat,
    input  logic              pend_busy,
    output logic              shared,
    output logic              retry,
    output logic              ivn,
    output logic              ivn_dirty,
    output logic [DATA_W-1:0] ivn_data,
    output logic              upd_we,
    output mesi_t             upd_st,
    output logic              pend_set
);

    logic hit;
    assign hit = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);

    always_comb begin
        shared    = hit;
        retry     = 1'b0;
        ivn       = 1'b0;
        ivn_dirty = 1'b0;
        upd_we    = 1'b0;
        upd_st    = line_st;
        pend_set  = 1'b0;
        unique case (snp_cmd)
            CMD_RD: begin
                ivn       = hit;
                ivn_dirty = hit && (line_st == ST_M);
                upd_we    = hit && (line_st != ST_S);
                upd_st    = ST_S;
            end
            CMD_RWITM: begin
                if (hit && line_st == ST_M) begin
                    retry    = 1'b1;
                    pend_set = !pend_busy;
                end else begin
                    upd_we = hit;
                    upd_st = ST_I;
                end
            end
            CMD_INV: begin
                upd_we = hit && (line_st == ST_S);
                upd_st = ST_I;
            end
            default: ;
        endcase
        ivn_data = ivn ? line_dat : '0;
    end

    always_comb begin
        assert_dirty_needs_ivn_R6: assert (!ivn_dirty || ivn);
        assert_retry_needs_copy_R11: assert (!retry || shared);
    end

endmodule

// File: rtl/coh_cache_ctl.sv
module coh_cache_ctl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_done,
    input  logic              bus_shared_in,
    input  logic              bus_retry_in,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_retry,
    output logic              snp_ivn,
    output logic              snp_ivn_dirty,
    output logic [DATA_W-1:0] snp_ivn_data
);

    fsm_t  state_q, state_d;
    op_t   op_q, op_d;
    logic  shared_q, shared_d;
    logic  pend_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    logic [IDX_W-1:0] cidx, sidx;
    logic [TAG_W-1:0] ctag, stag;
    assign cidx = core_addr[IDX_W-1:0];
    assign ctag = core_addr[ADDR_W-1:IDX_W];
    assign sidx = snp_addr[IDX_W-1:0];
    assign stag = snp_addr[ADDR_W-1:IDX_W];

    mesi_t             a_st, b_st, f_st, s_st;
    logic [TAG_W-1:0]  a_tag, b_tag, c_tag, f_tag;
    logic [DATA_W-1:0] a_dat, b_dat, c_dat, f_dat;
    logic              f_we, f_fill, s_we, pend_set;
    logic [IDX_W-1:0]  f_idx;
    logic              c_hit;
    bcmd_t             cmd;

    assign c_hit = (a_st != ST_I) && (a_tag == ctag);

    coh_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cidx), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
        .b_idx(sidx), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat),
        .c_idx(pend_idx_q), .c_tag(c_tag), .c_dat(c_dat),
        .f_we(f_we), .f_fill(f_fill), .f_idx(f_idx), .f_st(f_st),
        .f_tag(f_tag), .f_dat(f_dat),
        .s_we(s_we), .s_idx(sidx), .s_st(s_st)
    );

    coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(stag),
        .line_st(b_st), .line_tag(b_tag), .line_dat(b_dat),
        .pend_busy(pend_q),
        .shared(snp_shared), .retry(snp_retry), .ivn(snp_ivn),
        .ivn_dirty(snp_ivn_dirty), .ivn_data(snp_ivn_data),
        .upd_we(s_we), .upd_st(s_st), .pend_set(pend_set)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_RD;
            shared_q   <= 1'b0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            rdata_q    <= '0;
        end else begin
            state_q  <= state_d;
            op_q     <= op_d;
            shared_q <= shared_d;
            rdata_q  <= rdata_d;
            if (pend_set) begin
                pend_q     <= 1'b1;
                pend_idx_q <= sidx;
            end else if (state_q == S_WAIT && op_q == OP_WBS && bus_done) begin
                pend_q <= 1'b0;
            end
        end
    end

    // bus-side outputs
    always_comb begin
        cmd       = CMD_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_req   = (state_q == S_ARB);
        if (state_q == S_ARB && bus_gnt) begin
            if (pend_q) begin
                cmd       = CMD_WB;
                bus_addr  = {c_tag, pend_idx_q};
                bus_wdata = c_dat;
            end else if (core_req && c_hit && core_we && a_st == ST_S) begin
                cmd      = CMD_INV;
                bus_addr = core_addr;
            end else if (core_req && !c_hit && a_st == ST_M) begin
                cmd       = CMD_WB;
                bus_addr  = {a_tag, cidx};
                bus_wdata = a_dat;
            end else if (core_req && !c_hit) begin
                cmd      = core_we ? CMD_RWITM : CMD_RD;
                bus_addr = core_addr;
            end
        end
    end
    assign bus_cmd    = cmd;
    assign core_ready = (state_q == S_RESP);
    assign core_rdata = rdata_q;

    // next state and line writes
    always_comb begin
        state_d  = state_q;
        op_d     = op_q;
        shared_d = shared_q;
        rdata_d  = rdata_q;
        f_we     = 1'b0;
        f_fill   = 1'b0;
        f_idx    = cidx;
        f_st     = ST_M;
        f_tag    = ctag;
        f_dat    = core_wdata;
        unique case (state_q)
            S_IDLE: begin
                if (!snp_valid) begin
                    if (pend_q) begin
                        state_d = S_ARB;
                    end else if (core_req && c_hit && !core_we) begin
                        rdata_d = a_dat;
                        state_d = S_RESP;
                    end else if (core_req && c_hit && a_st != ST_S) begin
                        f_we    = 1'b1;
                        f_fill  = 1'b1;
                        state_d = S_RESP;
                    end else if (core_req) begin
                        state_d = S_ARB;
                    end
                end
            end
            S_ARB: begin
                if (bus_gnt) begin
                    unique case (cmd)
                        CMD_NONE:  state_d = S_IDLE;
                        CMD_INV: begin
                            f_we    = 1'b1;
                            f_fill  = 1'b1;
                            state_d = S_RESP;
                        end
                        CMD_WB: begin
                            op_d    = pend_q ? OP_WBS : OP_WBV;
                            state_d = S_WAIT;
                        end
                        default: begin
                            if (!bus_retry_in) begin
                                op_d     = (cmd == CMD_RWITM) ? OP_RWITM : OP_RD;
                                shared_d = bus_shared_in;
                                state_d  = S_WAIT;
                            end
                        end
                    endcase
                end
            end
            S_WAIT: begin
                if (bus_done) begin
                    unique case (op_q)
                        OP_WBS: begin
                            f_we    = 1'b1;
                            f_idx   = pend_idx_q;
                            f_st    = ST_I;
                            state_d = S_IDLE;
                        end
                        OP_WBV: begin
                            f_we    = 1'b1;
                            f_st    = ST_I;
                            state_d = S_ARB;
                        end
                        OP_RD: begin
                            f_we    = 1'b1;
                            f_fill  = 1'b1;
                            f_st    = shared_q ? ST_S : ST_E;
                            f_dat   = bus_rdata;
                            rdata_d = bus_rdata;
                            state_d = S_RESP;
                        end
                        OP_RWITM: begin
                            f_we    = 1'b1;
                            f_fill  = 1'b1;
                            state_d = S_RESP;
                        end
                    endcase
                end
            end
            S_RESP: state_d = S_IDLE;
        endcase
    end

    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> !core_ready);
    assert_inv_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_INV) |=> core_ready);
    assert_retry_records_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_retry && !pend_q) |=> pend_q);
    assert_victim_then_fill_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && op_q == OP_WBV && bus_done) |=> bus_req);
    assert_retry_reissues_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_retry_in && (bus_cmd == CMD_RD || bus_cmd == CMD_RWITM)) |=> bus_req);

endmodule

// File: tb/coh_cache_ctl_tb_top.sv
module coh_cache_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              rst_n;
    logic              core_req, core_we;
    logic [ADDR_W-1:0] core_addr;
    logic [DATA_W-1:0] core_wdata, core_rdata;
    logic              core_ready;
    logic              bus_req, bus_gnt, bus_done, bus_shared_in, bus_retry_in;
    logic [2:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    logic              snp_valid;
    logic [2:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic              snp_shared, snp_retry, snp_ivn, snp_ivn_dirty;
    logic [DATA_W-1:0] snp_ivn_data;

    coh_cache_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ready(core_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
        .bus_shared_in(bus_shared_in), .bus_retry_in(bus_retry_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_retry(snp_retry), .snp_ivn(snp_ivn),
        .snp_ivn_dirty(snp_ivn_dirty), .snp_ivn_data(snp_ivn_data)
    );

    int errors = 0;
    int checks = 0;

    // bus environment: always grants; memory answers one cycle after the address phase
    logic env_shared = 1'b0;
    int   retry_target = 0;
    int   retries_done = 0;
    int   log_n = 0;
    logic [2:0]        log_cmd  [64];
    logic [ADDR_W-1:0] log_addr [64];
    logic [DATA_W-1:0] log_data [64];
    logic              pend_done = 1'b0;
    logic [DATA_W-1:0] pend_data = '0;

    assign bus_gnt       = bus_req;
    assign bus_shared_in = env_shared;

    function automatic logic [DATA_W-1:0] memv(input logic [ADDR_W-1:0] a);
        return {16'hC0DE, a};
    endfunction

    initial begin
        bus_done     = 1'b0;
        bus_rdata    = '0;
        bus_retry_in = 1'b0;
    end

    always @(negedge clk) begin
        bus_done     = 1'b0;
        bus_retry_in = 1'b0;
        if (pend_done) begin
            bus_done  = 1'b1;
            bus_rdata = pend_data;
            pend_done = 1'b0;
        end else if (rst_n && bus_cmd != 3'd0) begin
            if (log_n < 64) begin
                log_cmd[log_n]  = bus_cmd;
                log_addr[log_n] = bus_addr;
                log_data[log_n] = bus_wdata;
                log_n++;
            end
            if ((bus_cmd == 3'd1 || bus_cmd == 3'd2) && retries_done < retry_target) begin
                bus_retry_in = 1'b1;
                retries_done++;
            end else if (bus_cmd != 3'd3) begin
                pend_done = 1'b1;
                pend_data = memv(bus_addr);
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic core_op(input logic we, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] rd);
        bit done = 0;
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
        rd = '0;
        for (int i = 0; i < 60 && !done; i++) begin
            @(negedge clk);
            if (core_ready) begin
                done = 1;
                rd = core_rdata;
            end
        end
        core_req = 1'b0;
        chk(done, "R1", "core access completes", {31'd0, done}, 32'd1);
    endtask

    task automatic snoop(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                         output logic [3:0] flags, output logic [DATA_W-1:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        flags = {snp_shared, snp_retry, snp_ivn, snp_ivn_dirty};
        d = snp_ivn_data;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 3'd0; snp_addr = '0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset_and_fill();
        logic [DATA_W-1:0] rd;
        int b;
        chk_eq("R1", "core_ready after reset", {31'd0, core_ready}, 32'd0);
        chk_eq("R1", "bus_req after reset", {31'd0, bus_req}, 32'd0);
        b = log_n;
        core_op(1'b0, 16'h0001, '0, rd);
        chk_eq("R1", "miss issues one command", log_n - b, 1);
        chk_eq("R1", "command is RD", {29'd0, log_cmd[b]}, 32'd1);
        chk_eq("R3", "fill word", rd, memv(16'h0001));
    endtask

    task automatic t_hits_and_silent_upgrade();
        logic [DATA_W-1:0] rd, sd;
        logic [3:0] fl;
        int b;
        b = log_n;
        core_op(1'b0, 16'h0001, '0, rd);
        chk_eq("R2", "read hit word", rd, memv(16'h0001));
        snoop(3'd1, 16'h0009, fl, sd);
        chk_eq("R13", "foreign tag snoop flags", {28'd0, fl}, 32'd0);
        core_op(1'b1, 16'h0001, 32'h1111_0001, rd);
        core_op(1'b1, 16'h0001, 32'h2222_0001, rd);
        core_op(1'b0, 16'h0001, '0, rd);
        chk_eq("R7", "no bus traffic for hits on E/M", log_n - b, 0);
        chk_eq("R7", "word after writes", rd, 32'h2222_0001);
    endtask

    task automatic t_snoop_dirty_then_rwitm();
        logic [DATA_W-1:0] rd, sd;
        logic [3:0] fl;
        int b;
        snoop(3'd1, 16'h0001, fl, sd);
        chk_eq("R6", "flags shared,retry,ivn,dirty", {28'd0, fl}, 32'hB);
        chk_eq("R6", "intervention word", sd, 32'h2222_0001);
        snoop(3'd2, 16'h0001, fl, sd);
        chk_eq("R10", "RWITM on S flags", {28'd0, fl}, 32'h8);
        b = log_n;
        core_op(1'b0, 16'h0001, '0, rd);
        chk_eq("R10", "line dropped, read goes to bus", {29'd0, log_cmd[b]}, 32'd1);
        chk_eq("R10", "one bus command", log_n - b, 1);
    endtask

    task automatic t_shared_fill_and_inv();
        logic [DATA_W-1:0] rd, sd;
        logic [3:0] fl;
        int b;
        env_shared = 1'b1;
        core_op(1'b0, 16'h0002, '0, rd);
        core_op(1'b0, 16'h0003, '0, rd);
        env_shared = 1'b0;
        b = log_n;
        core_op(1'b1, 16'h0002, 32'h3333_0002, rd);
        chk_eq("R4", "write to shared fill issues one command", log_n - b, 1);
        chk_eq("R8", "upgrade command is INV", {29'd0, log_cmd[b]}, 32'd3);
        chk_eq("R8", "INV address", {16'd0, log_addr[b]}, 32'h0002);
        b = log_n;
        core_op(1'b0, 16'h0002, '0, rd);
        chk_eq("R8", "word after upgrade", rd, 32'h3333_0002);
        chk_eq("R8", "line now Modified, no bus", log_n - b, 0);
        snoop(3'd3, 16'h0003, fl, sd);
        b = log_n;
        core_op(1'b0, 16'h0003, '0, rd);
        chk_eq("R8", "snooped INV drops S line", {29'd0, log_cmd[b]}, 32'd1);
    endtask

    task automatic t_write_miss_and_forced_wb();
        logic [DATA_W-1:0] rd, sd;
        logic [3:0] fl;
        int b;
        b = log_n;
        core_op(1'b1, 16'h0004, 32'h4444_0004, rd);
        chk_eq("R9", "write miss command is RWITM", {29'd0, log_cmd[b]}, 32'd2);
        b = log_n;
        core_op(1'b0, 16'h0004, '0, rd);
        chk_eq("R9", "merged word", rd, 32'h4444_0004);
        chk_eq("R9", "line Modified, hit", log_n - b, 0);
        snoop(3'd2, 16'h0004, fl, sd);
        chk_eq("R11", "RWITM on M flags", {28'd0, fl}, 32'hC);
        b = log_n;
        settle();
        chk_eq("R11", "one forced command", log_n - b, 1);
        chk_eq("R11", "forced command is WB", {29'd0, log_cmd[b]}, 32'd4);
        chk_eq("R11", "WB address", {16'd0, log_addr[b]}, 32'h0004);
        chk_eq("R11", "WB word", log_data[b], 32'h4444_0004);
        b = log_n;
        core_op(1'b0, 16'h0004, '0, rd);
        chk_eq("R11", "line Invalid after WB", {29'd0, log_cmd[b]}, 32'd1);
    endtask

    task automatic t_victims();
        logic [DATA_W-1:0] rd, sd;
        logic [3:0] fl;
        int b;
        core_op(1'b1, 16'h0005, 32'h5555_0005, rd);
        b = log_n;
        core_op(1'b0, 16'h000D, '0, rd);
        chk_eq("R12", "dirty victim: two commands", log_n - b, 2);
        chk_eq("R12", "first is WB", {29'd0, log_cmd[b]}, 32'd4);
        chk_eq("R12", "WB address", {16'd0, log_addr[b]}, 32'h0005);
        chk_eq("R12", "WB word", log_data[b], 32'h5555_0005);
        chk_eq("R12", "second is RD", {29'd0, log_cmd[b+1]}, 32'd1);
        chk_eq("R12", "fill word", rd, memv(16'h000D));
        core_op(1'b0, 16'h0006, '0, rd);
        b = log_n;
        core_op(1'b0, 16'h000E, '0, rd);
        chk_eq("R12", "clean victim: only RD", log_n - b, 1);
        chk_eq("R12", "command is RD", {29'd0, log_cmd[b]}, 32'd1);
        snoop(3'd1, 16'h000E, fl, sd);
        chk_eq("R5", "RD on E flags", {28'd0, fl}, 32'hA);
        chk_eq("R5", "intervention word", sd, memv(16'h000E));
        b = log_n;
        core_op(1'b1, 16'h000E, 32'h6666_000E, rd);
        chk_eq("R5", "E dropped to S, write issues INV", {29'd0, log_cmd[b]}, 32'd3);
    endtask

    task automatic t_own_retry();
        logic [DATA_W-1:0] rd;
        int b;
        retry_target = retries_done + 1;
        b = log_n;
        core_op(1'b0, 16'h0007, '0, rd);
        chk_eq("R14", "RD issued twice", log_n - b, 2);
        chk_eq("R14", "reissued command is RD", {29'd0, log_cmd[b+1]}, 32'd1);
        chk_eq("R14", "fill after retry", rd, memv(16'h0007));
    endtask

    initial begin
        rst_n = 1'b0;
        core_req = 1'b0; core_we = 1'b0; core_addr = '0; core_wdata = '0;
        snp_valid = 1'b0; snp_cmd = 3'd0; snp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_fill();
        t_hits_and_silent_upgrade();
        t_snoop_dirty_then_rwitm();
        t_shared_fill_and_inv();
        t_write_miss_and_forced_wb();
        t_victims();
        t_own_retry();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule